// File: doc/BRIEF.md
# Segmented Trigger Capture Buffer

This block is the storage engine of an on-chip logic analyzer. On every acquisition clock it can write one sample word into an internal memory. It runs in one of two modes. In single mode the whole memory is one ring buffer. In segmented mode the memory is split into equal rings, and each ring waits for its own trigger. The rings fill one after another, and only one of them is written at any time.

A trigger fixes a point in the ring. After it, a selectable number of further samples is stored, and the rest of the ring keeps the history from before the trigger. The address of each trigger sample is latched per segment, so the host can rotate each ring into time order. In single mode a qualifier input decides which samples are kept.

An arm pulse starts an acquisition and latches the mode and the trigger position. A done flag rises when the last region is complete. After that, the host reads the memory through a synchronous read port.

Top module: `seg_cap_buf`

## Requirements
- R1: After reset, `done_o` is 0, `rd_data_o` is 0 and every trigger address field is 0.
- R2: A one-cycle `arm_i` clears the segment index, the write pointer and done. It also latches `seg_mode_i` (0 = single ring, 1 = segmented) and `pos_i` (0 = pre, 1 = center, 2 = post, 3 = center). Samples are taken from the next cycle on.
- R3: In single mode a sample is written only when `smp_qual_i` is 1. Written samples go to consecutive addresses modulo DEPTH, counted from 0 after arm. An unqualified sample neither writes nor advances the pointer, and a trigger on it is ignored.
- R4: In segmented mode `smp_qual_i` is ignored and every cycle is written. Segment s occupies addresses s*SEG_DEPTH to s*SEG_DEPTH+SEG_DEPTH-1. Its pointer starts at 0 and wraps inside that range. SEG_DEPTH = DEPTH/NSEG.
- R5: A trigger on a stored sample, while the active region still waits for its trigger, latches that sample's address into the trigger field of the active segment. The field for segment s is bits s*ADDR_W and up of `trig_addr_o`; single mode uses field 0.
- R6: After the trigger sample, exactly N further samples are stored in the region. With region depth D (DEPTH in single mode, SEG_DEPTH in segmented mode), N = D-D/8 for pre, D/2 for center and D/8 for post.
- R7: A trigger during the N post-trigger samples is ignored. It changes neither the trigger address nor the count.
- R8: When a segment's last sample is stored, the next stored sample goes to the next segment at pointer 0. When the last segment, or the single ring, completes, `done_o` is 1 from the next cycle and nothing more is written.
- R9: A trigger is accepted even when the region has not yet filled, including on its very first sample.
- R10: When `rd_en_i` is 1 while done is 1, the word at `rd_addr_i` appears on `rd_data_o` one cycle later. While done is 0, `rd_data_o` holds its value.
- R11: `arm_i` takes priority over a sample in the same cycle, which is not stored. An arm during an acquisition restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Acquisition clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Start or restart an acquisition |
| seg_mode_i | input | 1 | 0 single ring, 1 segmented (latched at arm) |
| pos_i | input | 2 | Trigger position select (latched at arm) |
| smp_data_i | input | DATA_W | Sample word |
| smp_qual_i | input | 1 | Storage qualifier (single mode) |
| smp_trig_i | input | 1 | Trigger strobe |
| done_o | output | 1 | Acquisition complete |
| trig_addr_o | output | NSEG*ADDR_W | Trigger address per segment |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data, one cycle latency |

## Verification
Two collisions matter. A trigger can arrive on the same sample that closes a segment or ends the post-trigger count, and an arm can coincide with a valid sample. The bench provokes the first with high-rate random triggers that also fall inside post-trigger windows. It then judges the outcome from the latched trigger addresses and from every memory word that a requirement-based model says was written. For the second, the bench re-arms mid-acquisition with data present, and the model expects that sample to be absent and the new segment 0 to start at pointer 0.

// File: rtl/seg_cap_pkg.sv
package seg_cap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEEK = 2'd1,
      ST_POST = 2'd2,
      ST_DONE = 2'd3
   } cap_state_e;

   localparam logic [1:0] POS_EARLY = 2'd0;
   localparam logic [1:0] POS_MID   = 2'd1;
   localparam logic [1:0] POS_LATE  = 2'd2;
endpackage

// File: rtl/seg_cap_mem.sv
module seg_cap_mem #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              done_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (wr_en_i) store_q[wr_addr_i] <= wr_data_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                rd_data_o <= '0;
      else if (rd_en_i && done_i) rd_data_o <= store_q[rd_addr_i];
   end

   AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_i |=> $stable(rd_data_o)); // R10
   AST_NO_WRITE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> !wr_en_i); // R8
endmodule

// File: rtl/seg_cap_ctrl.sv
module seg_cap_ctrl
   import seg_cap_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int SEG_LOG2 = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                arm_i,
   input  logic                seg_mode_i,
   input  logic [1:0]          pos_i,
   input  logic                qual_i,
   input  logic                trig_i,
   output logic                wr_en_o,
   output logic [ADDR_W-1:0]   wr_addr_o,
   output logic                take_o,
   output logic [SEG_LOG2-1:0] take_seg_o,
   output logic                post_o,
   output logic                done_o
);
   localparam int SEG_AW = ADDR_W - SEG_LOG2;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int SEG_D  = 1 << SEG_AW;
   localparam int NSEG   = 1 << SEG_LOG2;
   localparam int REM_W  = ADDR_W + 1;
   localparam logic [SEG_LOG2-1:0] LAST_SEG = SEG_LOG2'(NSEG - 1);

   cap_state_e          state_q;
   logic                mode_q;
   logic [1:0]          pos_q;
   logic [SEG_LOG2-1:0] seg_q;
   logic [ADDR_W-1:0]   ptr_q;
   logic [REM_W-1:0]    rem_q;
   logic [REM_W-1:0]    region;
   logic [REM_W-1:0]    post_len;
   logic                active;

   always_comb begin
      region = mode_q ? REM_W'(SEG_D) : REM_W'(DEPTH);
      unique case (pos_q)
         POS_EARLY: post_len = region - (region >> 3);
         POS_LATE:  post_len = region >> 3;
         default:   post_len = region >> 1;
      endcase
   end

   assign active     = (state_q == ST_SEEK) || (state_q == ST_POST);
   assign wr_en_o    = active && !arm_i && (mode_q || qual_i);
   assign wr_addr_o  = mode_q ? {seg_q, ptr_q[SEG_AW-1:0]} : ptr_q;
   assign take_o     = wr_en_o && (state_q == ST_SEEK) && trig_i;
   assign take_seg_o = mode_q ? seg_q : '0;
   assign post_o     = (state_q == ST_POST);
   assign done_o     = (state_q == ST_DONE);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         mode_q  <= 1'b0;
         pos_q   <= POS_MID;
         seg_q   <= '0;
         ptr_q   <= '0;
         rem_q   <= '0;
      end else if (arm_i) begin
         state_q <= ST_SEEK;
         mode_q  <= seg_mode_i;
         pos_q   <= pos_i;
         seg_q   <= '0;
         ptr_q   <= '0;
         rem_q   <= '0;
      end else if (wr_en_o) begin
         if (state_q == ST_SEEK) begin
            ptr_q <= ptr_q + 1'b1;
            if (trig_i) begin
               rem_q   <= post_len;
               state_q <= ST_POST;
            end
         end else if (rem_q == REM_W'(1)) begin
            rem_q <= '0;
            if (!mode_q || seg_q == LAST_SEG) begin
               state_q <= ST_DONE;
            end else begin
               state_q <= ST_SEEK;
               seg_q   <= seg_q + 1'b1;
               ptr_q   <= '0;
            end
         end else begin
            rem_q <= rem_q - 1'b1;
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   AST_ARM_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_i |=> (ptr_q == '0 && seg_q == '0 && !done_o)); // R2
   AST_QUAL_HOLDS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!arm_i && !mode_q && !qual_i) |=> $stable(ptr_q)); // R3
   AST_POST_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (post_o && wr_en_o && rem_q != REM_W'(1)) |=> (rem_q == $past(rem_q) - 1'b1)); // R6
   AST_SEG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !arm_i |=> (seg_q == $past(seg_q) || seg_q == $past(seg_q) + 1'b1)); // R8
   AST_DONE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> $past(wr_en_o)); // R8
endmodule

// File: rtl/seg_cap_trig_regs.sv
module seg_cap_trig_regs #(
   parameter int ADDR_W   = 6,
   parameter int SEG_LOG2 = 2
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     take_i,
   input  logic [SEG_LOG2-1:0]      seg_i,
   input  logic [ADDR_W-1:0]        addr_i,
   output logic [(1<<SEG_LOG2)*ADDR_W-1:0] trig_addr_o
);
   localparam int NSEG = 1 << SEG_LOG2;

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      logic [ADDR_W-1:0] slot_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni)                                  slot_q <= '0;
         else if (take_i && seg_i == SEG_LOG2'(g))     slot_q <= addr_i;
      end
      assign trig_addr_o[g*ADDR_W +: ADDR_W] = slot_q;
   end

   AST_ONE_SLOT_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !take_i |=> $stable(trig_addr_o)); // R5
endmodule

// File: rtl/seg_cap_buf.sv
module seg_cap_buf #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 6,
   parameter int SEG_LOG2 = 2
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              arm_i,
   input  logic                              seg_mode_i,
   input  logic [1:0]                        pos_i,
   input  logic [DATA_W-1:0]                 smp_data_i,
   input  logic                              smp_qual_i,
   input  logic                              smp_trig_i,
   output logic                              done_o,
   output logic [(1<<SEG_LOG2)*ADDR_W-1:0]   trig_addr_o,
   input  logic                              rd_en_i,
   input  logic [ADDR_W-1:0]                 rd_addr_i,
   output logic [DATA_W-1:0]                 rd_data_o
);
   if (SEG_LOG2 < 1) begin : g_bad_seg
      $error("SEG_LOG2 must be at least 1");
   end
   if (ADDR_W - SEG_LOG2 < 3) begin : g_bad_depth
      $error("segment depth must be at least 8");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic                wr_en;
   logic [ADDR_W-1:0]   wr_addr;
   logic                take;
   logic [SEG_LOG2-1:0] take_seg;
   logic                in_post;

   seg_cap_ctrl #(.ADDR_W(ADDR_W), .SEG_LOG2(SEG_LOG2)) ctrl_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .seg_mode_i(seg_mode_i),
      .pos_i(pos_i), .qual_i(smp_qual_i), .trig_i(smp_trig_i),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .take_o(take), .take_seg_o(take_seg),
      .post_o(in_post), .done_o(done_o)
   );

   seg_cap_trig_regs #(.ADDR_W(ADDR_W), .SEG_LOG2(SEG_LOG2)) trig_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .seg_i(take_seg),
      .addr_i(wr_addr), .trig_addr_o(trig_addr_o)
   );

   seg_cap_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(smp_data_i), .done_i(done_o), .rd_en_i(rd_en_i),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
   );

   AST_TRIG_IGNORED_IN_POST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_post && !arm_i) |=> $stable(trig_addr_o)); // R7
endmodule

// File: tb/seg_cap_buf_tb_top.sv
module seg_cap_buf_tb_top;
   localparam int DATA_W   = 8;
   localparam int ADDR_W   = 6;
   localparam int SEG_LOG2 = 2;
   localparam int DEPTH    = 1 << ADDR_W;
   localparam int NSEG     = 1 << SEG_LOG2;
   localparam int SEG_D    = DEPTH / NSEG;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0, mode = 1'b0, qual = 1'b0, trig = 1'b0, rd_en = 1'b0;
   logic [1:0] pos = 2'd0;
   logic [DATA_W-1:0] data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic done;
   logic [NSEG*ADDR_W-1:0] taddr;
   logic [DATA_W-1:0] rd_data;

   always #2 clk = ~clk;

   seg_cap_buf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEG_LOG2(SEG_LOG2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .seg_mode_i(mode), .pos_i(pos),
      .smp_data_i(data), .smp_qual_i(qual), .smp_trig_i(trig), .done_o(done),
      .trig_addr_o(taddr), .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
   );

   int checks = 0, errors = 0;
   int mmem [DEPTH];
   bit mknown [DEPTH];
   int mtrig [NSEG];
   int mstate = 0, mseg = 0, mptr = 0, mrem = 0;
   bit mmode = 0;
   int mpos = 0;
   logic [DATA_W-1:0] rd_hold;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int post_len(input bit m, input int p);
      int d = m ? SEG_D : DEPTH;
      if (p == 0) return d - d / 8;
      if (p == 2) return d / 8;
      return d / 2;
   endfunction

   // drive one cycle (called at a negedge), update the model, check at next negedge
   task automatic step(input bit a, input bit sm, input int sp,
                       input int d, input bit q, input bit t, input string tag);
      arm = a; mode = sm; pos = 2'(sp); data = DATA_W'(d); qual = q; trig = t;
      if (a) begin
         mstate = 1; mseg = 0; mptr = 0; mrem = 0; mmode = sm; mpos = sp;
      end else if ((mstate == 1 || mstate == 2) && (mmode || q)) begin
         int ad = mmode ? (mseg * SEG_D + (mptr % SEG_D)) : (mptr % DEPTH);
         mmem[ad] = d & ((1 << DATA_W) - 1);
         mknown[ad] = 1;
         if (mstate == 1) begin
            mptr++;
            if (t) begin
               mtrig[mmode ? mseg : 0] = ad;
               mrem = post_len(mmode, mpos);
               mstate = 2;
            end
         end else begin
            mrem--;
            if (mrem == 0) begin
               if (!mmode || mseg == NSEG - 1) mstate = 3;
               else begin mseg++; mptr = 0; mstate = 1; end
            end else mptr++;
         end
      end
      @(negedge clk);
      arm = 1'b0;
      chk({tag, " R8 done"}, int'(done), int'(mstate == 3));
      if (!done) chk("R10 hold", int'(rd_data), int'(rd_hold));
   endtask

   task automatic verify(input string tag);
      for (int s = 0; s < NSEG; s++)
         chk({tag, " R5 trig addr"}, int'(taddr[s*ADDR_W +: ADDR_W]), mtrig[s]);
      for (int a = 0; a < DEPTH; a++) begin
         rd_en = 1'b1; rd_addr = ADDR_W'(a);
         @(negedge clk);
         if (mknown[a]) chk({tag, " R6 mem"}, int'(rd_data), mmem[a]);
      end
      rd_en = 1'b0;
      rd_hold = rd_data;
   endtask

   // run from arm to done with random stream; early=trigger on first sample
   task automatic run_case(input bit sm, input int sp, input bit early,
                           input int rate, input string tag);
      int n = 0;
      step(1, sm, sp, $urandom, 1, 0, tag);
      rd_en = 1'b1;
      while (mstate != 3 && n < 3000) begin
         bit q = sm ? bit'($urandom % 2) : bit'(($urandom % 4) != 0);
         bit t = (early && n == 0) ? 1'b1 : bit'(($urandom % rate) == 0);
         rd_addr = ADDR_W'($urandom);
         step(0, sm, sp, $urandom, early && n == 0 ? 1'b1 : q, t, tag);
         n++;
      end
      rd_en = 1'b0;
      verify(tag);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R8 actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int s = 0; s < NSEG; s++) mtrig[s] = 0;
      for (int a = 0; a < DEPTH; a++) mknown[a] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done", int'(done), 0);
      chk("R1 rd_data", int'(rd_data), 0);
      chk("R1 trig", int'(taddr), 0);
      rd_hold = rd_data;

      // all mode/position combinations, qualifier random (R3, R4, R6)
      for (int m = 0; m < 2; m++)
         for (int p = 0; p < 3; p++)
            run_case(bit'(m), p, 0, 10, m ? "R4 seg" : "R3 single");

      // R9: trigger on first sample of every region
      run_case(1, 0, 1, 1, "R9 early seg");
      chk("R9 seg0 addr", int'(taddr[0 +: ADDR_W]), 0);
      run_case(0, 2, 1, 1, "R9 early single");
      chk("R9 single addr", int'(taddr[0 +: ADDR_W]), 0);

      // R7: trigger every cycle, post-window triggers must be ignored
      run_case(1, 1, 0, 1, "R7 dense seg");
      run_case(0, 0, 0, 2, "R7 dense single");

      // position code 3 behaves as center (R2)
      run_case(1, 3, 0, 6, "R2 alias");

      // R11: restart mid-acquisition, arm cycle data not stored
      step(1, 0, 2, 1, 1, 0, "R11");
      for (int i = 0; i < 5; i++) step(0, 0, 2, 100 + i, 1, i == 2, "R11");
      step(1, 1, 2, 77, 1, 1, "R11 arm");
      rd_en = 1'b1;
      for (int i = 0; i < 200 && mstate != 3; i++) begin
         rd_addr = ADDR_W'($urandom);
         step(0, 1, 2, 200 + i, 0, (i % 5) == 1, "R11");
      end
      rd_en = 1'b0;
      verify("R11 restart");
      chk("R11 seg0 trig", int'(taddr[0 +: ADDR_W]), 1);

      // after done, further samples not stored (R8)
      for (int i = 0; i < 4; i++) step(0, 1, 2, 9, 1, 1, "R8 idle");
      verify("R8 after done");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule